// File: doc/BRIEF.md
# Oscilloscope Trace Pixel Renderer

This block turns a stream of signed 8-bit samples into a one-pixel-wide waveform trace on a raster display. Incoming samples are written into a 512-word dual-port sample memory. A write pointer advances once for each accepted sample. During scan-out, the horizontal position from an external timing generator addresses the read port. The stored sample for that column is compared with the current line number minus a centring offset of 200. When the two are equal, the pixel is drawn white. Otherwise it is black.

The read port is clocked, so the memory can be mapped onto synchronous block RAM. That read costs one cycle. To keep the trace in the right column, the line-derived compare value and the active-video flag are delayed by the same single cycle before the comparison. The result then passes through one output register.

Sync generation, triggering and double buffering are handled elsewhere. The block expects a pixel-rate clock and a timing generator that supplies position and blanking.

Top module: `scope_trace_render`

## Requirements
- R1: Each sample presented with `smp_valid` high is stored, as an 8-bit two's-complement value, in a 512-entry memory at the current write address. It stays there until that address is written again.
- R2: After reset the write address is 0. It advances by one on each clock edge where `smp_valid` is high. It holds on every other edge, and data offered with `smp_valid` low changes no entry.
- R3: The write address wraps from 511 to 0, so the 513th sample after reset overwrites entry 0.
- R4: The read address is the horizontal position modulo 512, meaning its low 9 bits.
- R5: A pixel is lit, with `pix_r`, `pix_g` and `pix_b` all 1, when the stored sample for its column equals the low 8 bits of (`scan_y` − 200). Otherwise all three are 0. For example, sample 0x00 matches line 200 and sample 0xFF matches line 199.
- R6: The colour for a pixel whose position is presented before rising edge N appears on the outputs after rising edge N+1, a latency of two clocks. Consecutive pixels stream at one per clock with no gaps.
- R7: When `scan_active` is 0 for a pixel, all three colour outputs are 0 for that pixel, whatever the comparison gives.
- R8: When the write address and the read address are equal in the same cycle, the read returns the value stored before that write (read-first).
- R9: A synchronous active-high `rst` clears the write address and the colour outputs. The memory contents are kept.
- R10: The comparison is modulo 256. Line 456 (456 − 200 = 256) matches a stored 0x00 just as line 200 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | 8 | Signed sample to capture |
| smp_valid | input | 1 | Capture strobe for `smp_data` |
| scan_x | input | 10 | Horizontal scan position |
| scan_y | input | 10 | Vertical scan position (line number) |
| scan_active | input | 1 | High during visible pixels |
| pix_r | output | 1 | Red output |
| pix_g | output | 1 | Green output |
| pix_b | output | 1 | Blue output |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 9-bit write pointer for a 512-entry memory, 10-bit scan positions and a centre offset of 200. With these values a full sweep of 512 writes fits easily in the run, so the 511-to-0 pointer wrap and the overwrite of entry 0 can be reached. The 10-bit line number also reaches line 456, where the modulo-256 aliasing of the compare value shows. Both the extreme signed samples and the same-cycle read/write collision are exercised against a model memory kept in the bench.

// File: rtl/trace_pkg.sv
package trace_pkg;
   // Fixed latency of the clocked sample-memory read port, in cycles.
   localparam int unsigned RAM_RD_LAT = 1;
   // Default geometry of the renderer.
   localparam int unsigned DEF_SAMPLE_W = 8;
   localparam int unsigned DEF_ADDR_W   = 9;
   localparam int unsigned DEF_POS_W    = 10;
   localparam int unsigned DEF_CENTRE   = 200;
endpackage

// File: rtl/trace_wr_ptr.sv
module trace_wr_ptr #(
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_w
         $error("trace_wr_ptr: ADDR_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (adv)
         ptr <= ptr + ONE;
   end

   // R2: pointer stays put when no sample is accepted
   a_r2_ptr_hold : assert property (@(posedge clk) disable iff (rst)
      (!rst && !adv) |=> $stable(ptr));
   // R3: pointer steps by one, wrapping at the top of the memory
   a_r3_ptr_step : assert property (@(posedge clk) disable iff (rst)
      (!rst && adv) |=> (ptr == ADDR_W'($past(ptr) + ONE)));
endmodule

// File: rtl/trace_sample_ram.sv
module trace_sample_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH > 4096) begin : g_too_deep
         $error("trace_sample_ram: depth exceeds 4096 words");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("trace_sample_ram: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   // Clocked read: the old word is sampled before any same-edge write lands.
   always_ff @(posedge clk) begin
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/trace_align.sv
module trace_align #(
   parameter int unsigned WIDTH  = 9,
   parameter int unsigned STAGES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_pipe
         logic [WIDTH-1:0] stage [STAGES+1];
         assign stage[0] = din;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst)
                  stage[s+1] <= '0;
               else
                  stage[s+1] <= stage[s];
            end
         end
         assign dout = stage[STAGES];
      end
   endgenerate
endmodule

// File: rtl/trace_match.sv
module trace_match #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              act_i,
   input  logic [DATA_W-1:0] cmp_i,
   input  logic [DATA_W-1:0] smp_i,
   output logic              pix_o
);
   logic hit;
   assign hit = act_i && (smp_i == cmp_i);

   always_ff @(posedge clk) begin
      if (rst)
         pix_o <= 1'b0;
      else
         pix_o <= hit;
   end

   // R7: blanked pixels stay dark
   a_r7_blank_dark : assert property (@(posedge clk) disable iff (rst)
      (!rst && !act_i) |=> !pix_o);
   // R5: an equal sample during active video lights the pixel
   a_r5_hit_lit : assert property (@(posedge clk) disable iff (rst)
      (!rst && act_i && (smp_i == cmp_i)) |=> pix_o);
endmodule

// File: rtl/scope_trace_render.sv
module scope_trace_render #(
   parameter int unsigned SAMPLE_W = trace_pkg::DEF_SAMPLE_W,
   parameter int unsigned ADDR_W   = trace_pkg::DEF_ADDR_W,
   parameter int unsigned POS_W    = trace_pkg::DEF_POS_W,
   parameter int unsigned CENTRE   = trace_pkg::DEF_CENTRE
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic [POS_W-1:0]    scan_x,
   input  logic [POS_W-1:0]    scan_y,
   input  logic                scan_active,
   output logic                pix_r,
   output logic                pix_g,
   output logic                pix_b
);
   localparam int unsigned ALIGN_W = SAMPLE_W + 1;
   localparam logic [POS_W-1:0] CENTRE_V = POS_W'(CENTRE);

   generate
      if (POS_W < ADDR_W) begin : g_bad_pos_addr
         $error("scope_trace_render: POS_W narrower than ADDR_W");
      end
      if (POS_W < SAMPLE_W) begin : g_bad_pos_smp
         $error("scope_trace_render: POS_W narrower than SAMPLE_W");
      end
      if (CENTRE >= (1 << POS_W)) begin : g_bad_centre
         $error("scope_trace_render: CENTRE does not fit POS_W");
      end
   endgenerate

   logic [ADDR_W-1:0]   wr_ptr;
   logic [SAMPLE_W-1:0] rd_smp;
   logic [POS_W-1:0]    y_off;
   logic [ALIGN_W-1:0]  line_now, line_dly;
   logic                pix;

   trace_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk (clk),
      .rst (rst),
      .adv (smp_valid),
      .ptr (wr_ptr)
   );

   trace_sample_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (smp_valid),
      .waddr (wr_ptr),
      .wdata (smp_data),
      .raddr (scan_x[ADDR_W-1:0]),
      .rdata (rd_smp)
   );

   assign y_off    = scan_y - CENTRE_V;
   assign line_now = {scan_active, y_off[SAMPLE_W-1:0]};

   trace_align #(.WIDTH(ALIGN_W), .STAGES(trace_pkg::RAM_RD_LAT)) u_align (
      .clk  (clk),
      .rst  (rst),
      .din  (line_now),
      .dout (line_dly)
   );

   trace_match #(.DATA_W(SAMPLE_W)) u_match (
      .clk   (clk),
      .rst   (rst),
      .act_i (line_dly[ALIGN_W-1]),
      .cmp_i (line_dly[SAMPLE_W-1:0]),
      .smp_i (rd_smp),
      .pix_o (pix)
   );

   assign pix_r = pix;
   assign pix_g = pix;
   assign pix_b = pix;

   // R9: reset leaves the pointer at zero and the outputs dark
   a_r9_reset_clears : assert property (@(posedge clk)
      rst |=> (!pix_r && !pix_g && !pix_b && (wr_ptr == '0)));
endmodule

// File: tb/sim_scope_trace_render.sv
`timescale 1ns/1ps
module sim_scope_trace_render;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] smp_data = '0;
   logic       smp_valid = 1'b0;
   logic [9:0] scan_x = '0;
   logic [9:0] scan_y = '0;
   logic       scan_active = 1'b0;
   logic       pix_r, pix_g, pix_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] model [512];
   int         m_ptr = 0;

   always #2.5 clk = ~clk;

   scope_trace_render u0 (
      .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
      .scan_x(scan_x), .scan_y(scan_y), .scan_active(scan_active),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
   );

   function automatic logic exp_pix(input logic [9:0] x, input logic [9:0] y,
                                    input logic act);
      logic [9:0] d;
      d = y - 10'd200;
      return act && (model[x[8:0]] == d[7:0]);
   endfunction

   function automatic logic [9:0] line_for(input logic [7:0] s);
      return 10'd200 + {{2{s[7]}}, s};
   endfunction

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: rgb actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = d;
      @(negedge clk);
      smp_valid = 1'b0;
      model[m_ptr] = d;
      m_ptr = (m_ptr + 1) % 512;
   endtask

   task automatic probe(input string req, input logic [9:0] x, input logic [9:0] y,
                        input logic act, input logic exp);
      @(negedge clk);
      scan_x = x; scan_y = y; scan_active = act;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(req, {pix_r, pix_g, pix_b}, {3{exp}});
      scan_active = 1'b0;
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      chk("R9 reset outputs", {pix_r, pix_g, pix_b}, 3'b000);
      rst = 1'b0;
   endtask

   // R1 R4 R5: full sweep then hits and misses, with signed extremes
   task automatic t_fill_and_hit;
      for (int i = 0; i < 512; i++) wr(8'((i * 7 + 3) & 255));
      for (int k = 0; k < 6; k++) begin
         logic [9:0] x;
         x = 10'(k * 83 + 5);
         probe("R1 R5 hit", x, line_for(model[x[8:0]]), 1'b1, 1'b1);
         probe("R5 miss", x, line_for(model[x[8:0]]) + 10'd1, 1'b1, 1'b0);
      end
      probe("R4 column wraps mod 512", 10'd600, line_for(model[88]), 1'b1, 1'b1);
   endtask

   // R3: 513th write after reset lands in entry 0
   task automatic t_wrap;
      wr(8'h11);
      probe("R3 wrap to entry 0", 10'd0, 10'd217, 1'b1, 1'b1);
      wr(8'h80);
      probe("R5 most negative sample", 10'd1, 10'd72, 1'b1, 1'b1);
      wr(8'h7F);
      probe("R5 most positive sample", 10'd2, 10'd327, 1'b1, 1'b1);
      wr(8'hFF);
      probe("R5 minus one on line 199", 10'd3, 10'd199, 1'b1, 1'b1);
   endtask

   // R2: data without the strobe is dropped and the pointer holds
   task automatic t_hold;
      int p;
      p = m_ptr;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         smp_data = 8'(8'hA0 + i);
      end
      probe("R2 no write without strobe", 10'(p), line_for(model[p]), 1'b1, 1'b1);
      wr(8'h55);
      probe("R2 pointer held", 10'(p), 10'd285, 1'b1, 1'b1);
   endtask

   // R7: matching sample during blanking stays dark
   task automatic t_blank;
      probe("R7 blank dark", 10'd0, 10'd217, 1'b0, 1'b0);
   endtask

   // R10: line 456 aliases to compare value 0
   task automatic t_alias;
      int p;
      p = m_ptr;
      wr(8'h00);
      probe("R10 line 456 matches zero", 10'(p), 10'd456, 1'b1, 1'b1);
      probe("R10 line 200 matches zero", 10'(p), 10'd200, 1'b1, 1'b1);
   endtask

   // R6: streamed pixels come out two clocks later, in order
   task automatic t_stream;
      logic ev [16];
      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         if (i >= 2)
            chk("R6 two-clock alignment", {pix_r, pix_g, pix_b}, {3{ev[i-2]}});
         if (i < 16) begin
            logic [9:0] x, y;
            x = 10'(100 + i);
            y = line_for(model[x[8:0]]) + ((i % 3 == 0) ? 10'd0 : 10'd1);
            scan_x = x; scan_y = y; scan_active = 1'b1;
            ev[i] = exp_pix(x, y, 1'b1);
         end else begin
            scan_active = 1'b0;
         end
      end
   endtask

   // R8: same-address write and read returns the old word
   task automatic t_read_first;
      int p;
      logic [7:0] old;
      p = m_ptr;
      old = model[p];
      @(negedge clk);
      smp_valid = 1'b1; smp_data = old ^ 8'h5A;
      scan_x = 10'(p); scan_y = line_for(old); scan_active = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0; scan_active = 1'b0;
      @(negedge clk);
      chk("R8 read-first old value", {pix_r, pix_g, pix_b}, 3'b111);
      model[p] = old ^ 8'h5A;
      m_ptr = (m_ptr + 1) % 512;
      probe("R8 new value after write", 10'(p), line_for(model[p]), 1'b1, 1'b1);
   endtask

   // R9: reset mid-run keeps memory, restarts pointer
   task automatic t_reset_keep;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 outputs cleared", {pix_r, pix_g, pix_b}, 3'b000);
      rst = 1'b0;
      m_ptr = 0;
      probe("R9 memory kept", 10'd300, line_for(model[300]), 1'b1, 1'b1);
      wr(8'h22);
      probe("R9 pointer back at 0", 10'd0, 10'd234, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_state();
      t_fill_and_hit();
      t_wrap();
      t_hold();
      t_blank();
      t_alias();
      t_stream();
      t_read_first();
      t_reset_keep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule